// File: doc/BRIEF.md
# Single-Wire Bus Read-Slot Master

This block is the master side of one read time slot on an open-drain single-wire bus. A one-cycle `start` request begins the slot. The block pulls the line low for a programmed number of cycles and then lets it go. A slave sending a 0 keeps the line low past that point. A slave sending a 1 leaves it alone, so the pull-up raises the line as soon as the master releases it.

The block takes one sample of the synchronized line late in the master's sampling window. It then keeps `busy` high until the full slot length plus an extra recovery guard has elapsed. The guard lengthens recovery on buses that carry several slaves. All four timing values are cycle counts taken from configuration inputs when the slot begins. Settings that break the order low time < sample point < slot length are clamped rather than rejected.

Top module: `owm_read_slot`

## Requirements
- R1: After reset, `busy`, `done`, `line_oe` and `rd_bit` are all 0.
- R2: The effective low time eL is `cfg_low_cycles`, or 1 when that input is 0. Number the cycles after the accepting clock edge as slot cycles 0, 1, 2, and so on. `line_oe` (1 = pull the line low) is 1 in slot cycles 0 to eL-1 and 0 in every other cycle.
- R3: The effective sample point is eS. The two-flop synchronizer on `line_in` adds latency, so `rd_bit` takes the level `line_in` had during slot cycle eS-2. `rd_bit` keeps that value until the sample of the next slot.
- R4: The effective sample point is eS = max(`cfg_sample_cycles`, eL+1). The effective slot length is eT = max(`cfg_slot_cycles`, eS+1).
- R5: `busy` is 1 for exactly eT + `cfg_guard_cycles` consecutive cycles, starting at slot cycle 0.
- R6: `done` is a one-cycle pulse in the first cycle after `busy` falls. `done` is never 1 while `busy` is 1.
- R7: A `start` that arrives while `busy` is 1 is ignored. The slot length and the result are unchanged.
- R8: The block captures the configuration inputs on the accepting edge. Changes to them while `busy` is 1 have no effect on the current slot.
- R9: A `start` held during the `done` cycle is accepted at once, so slots can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request to begin one read slot |
| cfg_low_cycles | input | CNT_W | Low time in cycles |
| cfg_sample_cycles | input | CNT_W | Sample point in cycles from the slot start |
| cfg_slot_cycles | input | CNT_W | Slot length in cycles |
| cfg_guard_cycles | input | CNT_W | Extra recovery cycles added to the slot |
| line_in | input | 1 | Asynchronous bus level (1 = high) |
| line_oe | output | 1 | 1 = drive the bus low |
| busy | output | 1 | Slot in progress, including recovery |
| done | output | 1 | One-cycle end-of-slot pulse |
| rd_bit | output | 1 | Bit read in the most recent slot |

## Verification
The bench builds the block with CNT_W = 4, so every configuration field spans 0 to 15. It sweeps low times 0–5, sample points 0–7, slot lengths 0–8 and guards 0–2. That sweep reaches every clamp branch, including the case where the slot ends in the same cycle as the sample. For each setting the bench runs three slave behaviours: a released line, a 0 held through the sample, and a 0 released exactly at the sampled cycle. It also adds the full-range extremes and mid-slot changes to `start` and the configuration inputs.

// File: rtl/owm_rd_pkg.sv
package owm_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LOW     = 2'd1,
    ST_SAMPLE  = 2'd2,
    ST_RECOVER = 2'd3
  } slot_st_e;
endpackage

// File: rtl/owm_rd_rst_sync.sv
module owm_rd_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stg_q <= 2'b00;
    else           stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_out = stg_q[1];
endmodule

// File: rtl/owm_rd_sync.sv
module owm_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_n;

  always_comb begin
    stg_n = {stg_q[STAGES-2:0], d_async};
  end

  // Idle bus level is high, so the flops reset to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '1;
    else        stg_q <= stg_n;
  end

  assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/owm_rd_clamp.sv
module owm_rd_clamp #(
  parameter int CNT_W = 10,
  parameter int EW    = CNT_W + 3
) (
  input  logic [CNT_W-1:0] cfg_low,
  input  logic [CNT_W-1:0] cfg_sample,
  input  logic [CNT_W-1:0] cfg_slot,
  input  logic [CNT_W-1:0] cfg_guard,
  output logic [EW-1:0]    eff_low,
  output logic [EW-1:0]    eff_sample,
  output logic [EW-1:0]    eff_end
);
  localparam int PADW = EW - CNT_W;
  localparam logic [EW-1:0] ONE = EW'(1);

  logic [EW-1:0] lo_w, sp_w, sl_w, gd_w;

  always_comb begin
    lo_w = {{PADW{1'b0}}, cfg_low};
    sp_w = {{PADW{1'b0}}, cfg_sample};
    sl_w = {{PADW{1'b0}}, cfg_slot};
    gd_w = {{PADW{1'b0}}, cfg_guard};
    // Low time of at least one cycle (R2).
    if (lo_w == '0) lo_w = ONE;
    // Sample strictly after the release (R4).
    if (sp_w <= lo_w) sp_w = lo_w + ONE;
    // Slot strictly after the sample (R4).
    if (sl_w <= sp_w) sl_w = sp_w + ONE;
    eff_low    = lo_w;
    eff_sample = sp_w;
    eff_end    = sl_w + gd_w - ONE;
  end
endmodule

// File: rtl/owm_rd_fsm.sv
module owm_rd_fsm
  import owm_rd_pkg::*;
#(
  parameter int EW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [EW-1:0] eff_low,
  input  logic [EW-1:0] eff_sample,
  input  logic [EW-1:0] eff_end,
  input  logic          line_s,
  output logic          busy,
  output logic          done,
  output logic          line_oe,
  output logic          rd_bit
);
  localparam logic [EW-1:0] ONE = EW'(1);

  slot_st_e      state, state_n;
  logic [EW-1:0] cnt, cnt_n;
  logic [EW-1:0] lat_low, lat_sample, lat_end;
  logic          load_cfg, cap_en, cnt_en, done_n;

  always_comb begin
    state_n  = state;
    cnt_n    = cnt + ONE;
    cnt_en   = 1'b0;
    load_cfg = 1'b0;
    cap_en   = 1'b0;
    done_n   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          load_cfg = 1'b1;
          cnt_en   = 1'b1;
          cnt_n    = '0;
          state_n  = ST_LOW;
        end
      end
      ST_LOW: begin
        cnt_en = 1'b1;
        if (cnt == lat_low - ONE) state_n = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        cnt_en = 1'b1;
        if (cnt == lat_sample) begin
          cap_en = 1'b1;
          if (cnt == lat_end) begin
            state_n = ST_IDLE;
            done_n  = 1'b1;
          end else begin
            state_n = ST_RECOVER;
          end
        end
      end
      ST_RECOVER: begin
        cnt_en = 1'b1;
        if (cnt == lat_end) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_n;
      done  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_low    <= ONE;
      lat_sample <= ONE + ONE;
      lat_end    <= ONE + ONE;
    end else if (load_cfg) begin
      lat_low    <= eff_low;
      lat_sample <= eff_sample;
      lat_end    <= eff_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_bit <= 1'b0;
    else if (cap_en) rd_bit <= line_s;
  end

  assign busy    = (state != ST_IDLE);
  assign line_oe = (state == ST_LOW);

  // R2: the line is released exactly when the count reaches the low time.
  p_release_point_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> (cnt == lat_low));

  // R3: the read bit only moves on the cycle that ends at the sample point.
  p_sample_point_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_bit) |-> ($past(busy) && $past(cnt) == $past(lat_sample)));

  // R4: the captured timing keeps low < sample <= last slot cycle.
  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lat_low < lat_sample) && (lat_sample <= lat_end));

  // R5 / R7: inside a slot the count only steps forward, whatever start does.
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (cnt == $past(cnt) + ONE));

  // R6: done is a single pulse right after the slot.
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R8: the captured configuration is frozen while busy.
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lat_low) && $stable(lat_sample) && $stable(lat_end)));
endmodule

// File: rtl/owm_read_slot.sv
module owm_read_slot #(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cfg_low_cycles,
  input  logic [CNT_W-1:0] cfg_sample_cycles,
  input  logic [CNT_W-1:0] cfg_slot_cycles,
  input  logic [CNT_W-1:0] cfg_guard_cycles,
  input  logic             line_in,
  output logic             line_oe,
  output logic             busy,
  output logic             done,
  output logic             rd_bit
);
  localparam int EW = CNT_W + 3;

  logic          rst_sn;
  logic          line_s;
  logic [EW-1:0] eff_low, eff_sample, eff_end;

  owm_rd_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sn)
  );

  owm_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sn),
    .d_async (line_in),
    .q_sync  (line_s)
  );

  owm_rd_clamp #(.CNT_W(CNT_W), .EW(EW)) u_clamp (
    .cfg_low    (cfg_low_cycles),
    .cfg_sample (cfg_sample_cycles),
    .cfg_slot   (cfg_slot_cycles),
    .cfg_guard  (cfg_guard_cycles),
    .eff_low    (eff_low),
    .eff_sample (eff_sample),
    .eff_end    (eff_end)
  );

  owm_rd_fsm #(.EW(EW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sn),
    .start      (start),
    .eff_low    (eff_low),
    .eff_sample (eff_sample),
    .eff_end    (eff_end),
    .line_s     (line_s),
    .busy       (busy),
    .done       (done),
    .line_oe    (line_oe),
    .rd_bit     (rd_bit)
  );
endmodule

// File: tb/owm_read_slot_bench.sv
module owm_read_slot_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [W-1:0] cfg_lo, cfg_sp, cfg_sl, cfg_gd;
  logic         line_in;
  logic         line_oe, busy, done, rd_bit;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 0;
  int  slot_cyc = 1000;
  bit  slv_zero = 0;
  int  slv_hold = 0;

  always #5 clk = ~clk;

  owm_read_slot #(.CNT_W(W)) u_owm_read_slot (
    .clk (clk), .rst_n (rst_n), .start (start),
    .cfg_low_cycles (cfg_lo), .cfg_sample_cycles (cfg_sp),
    .cfg_slot_cycles (cfg_sl), .cfg_guard_cycles (cfg_gd),
    .line_in (line_in), .line_oe (line_oe), .busy (busy),
    .done (done), .rd_bit (rd_bit)
  );

  // Slave and pull-up model: the bus is low while either side pulls it.
  always @(posedge clk) begin
    if (start && !busy)      slot_cyc <= 0;
    else if (slot_cyc < 1000) slot_cyc <= slot_cyc + 1;
  end
  assign line_in = !(line_oe || (slv_zero && slot_cyc < slv_hold));

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge. Returns at the negedge of the done cycle.
  task automatic run_slot(input int lo, input int sp, input int sl, input int gd,
                          input int pat, input bit disturb);
    int eL, eS, eT, total, c, oe_err, dn_err, expb, smp;
    eL = (lo == 0) ? 1 : lo;
    eS = (sp <= eL) ? eL + 1 : sp;
    eT = (sl <= eS) ? eS + 1 : sl;
    total = eT + gd;
    slv_zero = (pat != 0);
    slv_hold = (pat == 1) ? eS : eS - 2;
    smp = eS - 2;
    expb = (smp < eL || (slv_zero && smp < slv_hold)) ? 0 : 1;
    cfg_lo = W'(lo); cfg_sp = W'(sp); cfg_sl = W'(sl); cfg_gd = W'(gd);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    c = 0; oe_err = 0; dn_err = 0;
    while (busy && c < 200) begin
      if (line_oe != (c < eL)) oe_err++;
      if (done) dn_err++;
      if (disturb && c == 1) begin   // R7, R8: mid-slot start and config change
        start  = 1'b1;
        cfg_lo = W'($urandom); cfg_sp = W'($urandom);
        cfg_sl = W'($urandom); cfg_gd = W'($urandom);
      end
      if (disturb && c == 2) start = 1'b0;
      @(negedge clk);
      c++;
    end
    if (disturb) check("R7/R8 busy length with mid-slot start and config change", c, total);
    else         check("R5 busy length", c, total);
    check("R2 line_oe pattern errors", oe_err, 0);
    check("R6 done during busy", dn_err, 0);
    check("R6 done pulse after busy", int'(done), 1);
    check("R3 rd_bit", int'(rd_bit), expb);
    check("R2 line_oe after slot", int'(line_oe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    cfg_lo = '0; cfg_sp = '0; cfg_sl = '0; cfg_gd = '0;
    repeat (3) @(negedge clk);
    check("R1 busy at reset", int'(busy), 0);
    check("R1 done at reset", int'(done), 0);
    check("R1 line_oe at reset", int'(line_oe), 0);
    check("R1 rd_bit at reset", int'(rd_bit), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after release", int'(busy), 0);
    // Sweep covers R2, R3, R4, R5, R6; back-to-back starts cover R9.
    for (int lo = 0; lo <= 5; lo++)
      for (int sp = 0; sp <= 7; sp++)
        for (int sl = 0; sl <= 8; sl++)
          for (int gd = 0; gd <= 2; gd++)
            for (int pat = 0; pat < 3; pat++)
              run_slot(lo, sp, sl, gd, pat, gd == 2);
    // R4 full-range extremes.
    run_slot(15, 15, 15, 15, 0, 1'b0);
    run_slot(15, 0, 0, 0, 1, 1'b0);
    run_slot(0, 15, 0, 15, 2, 1'b0);
    run_slot(3, 14, 15, 15, 1, 1'b1);
    // R9: idle gap, then the start accepted straight after done.
    @(negedge clk);
    check("R9 idle after gap", int'(busy), 0);
    run_slot(2, 6, 9, 1, 0, 1'b0);
    run_slot(1, 2, 3, 0, 1, 1'b0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule